// File: doc/BRIEF.md
# Trigger Frame Packer

The block collects threshold-crossing results from a bank of channel integrators and packs them into one wide word for each fixed-length trigger frame. An external sync pulse sets the frame boundary. Each frame is eight clock periods long. Frames then repeat with no gap until another sync pulse realigns them. For each channel the block records the reduced sum presented with its first crossing in the frame, and the period index (0 to 7) at which that crossing happened. With this index a downstream processor can recover timing at single-clock resolution inside a frame that is eight clocks long.

At the end of every frame the packed word appears on the output for exactly one cycle, together with a valid strobe. A compile-time mode sets the entry size. In normal mode each entry is one byte: a 5-bit sum and a 3-bit index. In extended mode each entry is a 16-bit word: a 13-bit sum and a 3-bit index. The serializer and the line coding that follow the block are not part of it.

Top module: `frame_packer`

## Requirements
- R1: While reset is high, and after reset until the first sync pulse, frame_valid_o stays 0 and frame_o stays all zero, whatever arrives on hit_i and sum_i.
- R2: The cycle in which sync_i is high is period 0 of a frame. A frame is eight periods long. Once a frame ends at period 7, the next frame begins on the following cycle without a new sync.
- R3: frame_valid_o is high for exactly one cycle per completed frame: the cycle after period 7. The strobe therefore comes eight cycles after the sync cycle of an aligned frame.
- R4: The entry for channel k (counted from 0) occupies frame_o[k*ENTRY_W +: ENTRY_W], so channel 0 is in the least significant entry. Within an entry the sum is in the low SUM_W bits and the 3-bit period index is in the top three bits.
- R5: The period index of a reported entry equals the period (0 to 7) in which hit_i for that channel was high, and the sum equals sum_i for that channel in the same cycle.
- R6: When a channel has more than one hit in a frame, only the first hit's sum and period index are reported.
- R7: A channel with no hit in a frame reports an all-zero entry. sum_i is ignored in cycles where the channel's hit_i is low.
- R8: A sync pulse that arrives before period 7 of the current frame discards that partial frame: no strobe is produced for it, none of its hits appear in any later frame, and the sync cycle becomes period 0.
- R9: With EXTENDED=0 the sums are 5 bits and the entries 8 bits, giving a 128-bit frame. With EXTENDED=1 the sums are 13 bits and the entries 16 bits, giving a 256-bit frame.
- R10: frame_o holds its value in every cycle in which frame_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one frame period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame alignment pulse; its cycle is period 0 |
| hit_i | input | NUM_CH | Per-channel threshold-crossing strobe |
| sum_i | input | NUM_CH*SUM_W | Per-channel reduced sum, channel k at bits [k*SUM_W +: SUM_W] |
| frame_o | output | NUM_CH*ENTRY_W | Packed frame word |
| frame_valid_o | output | 1 | One-cycle strobe marking a new frame_o |

## Verification
On every cycle the assertions check the following: the strobe lasts a single cycle, it never follows a sync cycle directly, it falls on the phase eight clocks after the last alignment, the output word holds between strobes, and the outputs are clear after reset. Only the bench's scenarios can show the entry contents: the period index and sum of each channel at each period, first-hit selection, zero entries for silent channels, lane ordering, both entry widths, and the absence of any trace of a discarded partial frame.

// File: rtl/trig_frame_pkg.sv
package trig_frame_pkg;

    localparam int FRAME_CLKS = 8;
    localparam int TIME_W     = $clog2(FRAME_CLKS);

    typedef struct packed {
        logic              live;
        logic [TIME_W-1:0] cnt;
    } timer_t;

    function automatic int sum_width(input bit extended);
        return extended ? 13 : 5;
    endfunction

endpackage

// File: rtl/frame_timer.sv
module frame_timer
    import trig_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    output logic [TIME_W-1:0] period_o,
    output logic              active_o,
    output logic              fresh_o,
    output logic              done_o
);
    localparam logic [TIME_W-1:0] LAST = TIME_W'(FRAME_CLKS - 1);

    timer_t st_q, st_d;

    always_comb begin
        period_o = sync_i ? '0 : st_q.cnt;
        active_o = sync_i || st_q.live;
        fresh_o  = sync_i || (st_q.live && st_q.cnt == '0);
        done_o   = st_q.live && !sync_i && st_q.cnt == LAST;

        st_d = st_q;
        if (sync_i) begin
            st_d.live = 1'b1;
            st_d.cnt  = TIME_W'(1);
        end else if (st_q.live) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + TIME_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/frame_chan.sv
module frame_chan
    import trig_frame_pkg::*;
#(
    parameter  int SUM_W   = 5,
    localparam int ENTRY_W = SUM_W + TIME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active_i,
    input  logic               fresh_i,
    input  logic [TIME_W-1:0]  period_i,
    input  logic               hit_i,
    input  logic [SUM_W-1:0]   sum_i,
    output logic [ENTRY_W-1:0] entry_o
);
    logic               seen_q, seen_d;
    logic [ENTRY_W-1:0] ent_q, ent_d;

    always_comb begin
        seen_d = seen_q;
        ent_d  = ent_q;
        if (fresh_i) begin
            // first period of a frame: drop whatever the previous frame held
            seen_d = hit_i;
            ent_d  = hit_i ? {period_i, sum_i} : '0;
        end else if (active_i && hit_i && !seen_q) begin
            seen_d = 1'b1;
            ent_d  = {period_i, sum_i};
        end
    end

    assign entry_o = ent_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            ent_q  <= '0;
        end else begin
            seen_q <= seen_d;
            ent_q  <= ent_d;
        end
    end
endmodule

// File: rtl/frame_packer.sv
module frame_packer
    import trig_frame_pkg::*;
#(
    parameter  int NUM_CH   = 16,
    parameter  bit EXTENDED = 1'b0,
    localparam int SUM_W    = sum_width(EXTENDED),
    localparam int ENTRY_W  = SUM_W + TIME_W,
    localparam int FRAME_W  = NUM_CH * ENTRY_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sync_i,
    input  logic [NUM_CH-1:0]       hit_i,
    input  logic [NUM_CH*SUM_W-1:0] sum_i,
    output logic [FRAME_W-1:0]      frame_o,
    output logic                    frame_valid_o
);
    logic [TIME_W-1:0] period;
    logic              active, fresh, done;
    logic [FRAME_W-1:0] frame_next;

    frame_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_i),
        .period_o (period),
        .active_o (active),
        .fresh_o  (fresh),
        .done_o   (done)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        frame_chan #(.SUM_W(SUM_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .active_i (active),
            .fresh_i  (fresh),
            .period_i (period),
            .hit_i    (hit_i[g]),
            .sum_i    (sum_i[g*SUM_W +: SUM_W]),
            .entry_o  (frame_next[g*ENTRY_W +: ENTRY_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_o       <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= done;
            if (done) frame_o <= frame_next;
        end
    end
endmodule

// File: rtl/frame_packer_chk.sv
module frame_packer_chk #(
    parameter int FRAME_W = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               sync_i,
    input logic               frame_valid_o,
    input logic [FRAME_W-1:0] frame_o
);
    logic       armed;
    logic [2:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            phase <= '0;
        end else if (sync_i) begin
            armed <= 1'b1;
            phase <= 3'd1;
        end else begin
            phase <= phase + 3'd1;
        end
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!frame_valid_o && frame_o == '0));
    // R3
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |=> !frame_valid_o);
    // R8
    a_r8_sync_blocks_strobe: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> !frame_valid_o);
    // R2
    a_r2_strobe_aligned: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |-> (armed && phase == 3'd0));
    // R10
    a_r10_frame_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_valid_o |-> $stable(frame_o));
endmodule

bind frame_packer frame_packer_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sync_i        (sync_i),
    .frame_valid_o (frame_valid_o),
    .frame_o       (frame_o)
);

// File: tb/frame_packer_test.sv
module frame_packer_test;
    localparam int CLK_P = 10;
    localparam int NCH   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_i = 1'b0;
    logic [NCH-1:0]    hit_b = '0;
    logic [NCH*5-1:0]  sum_n = '0;
    logic [NCH*13-1:0] sum_e = '0;
    logic [NCH*8-1:0]  fr_n;
    logic [NCH*16-1:0] fr_e;
    logic              v_n, v_e;

    int checks = 0;
    int errors = 0;
    bit pending = 0;
    bit finished = 0;
    int fp [NCH];
    int sp [NCH];
    logic [NCH*8-1:0]  exp_n;
    logic [NCH*16-1:0] exp_e;

    always #(CLK_P/2) clk = ~clk;

    frame_packer #(.NUM_CH(NCH), .EXTENDED(1'b0)) uut (
        .clk(clk), .rst(rst), .sync_i(sync_i), .hit_i(hit_b), .sum_i(sum_n),
        .frame_o(fr_n), .frame_valid_o(v_n));

    frame_packer #(.NUM_CH(NCH), .EXTENDED(1'b1)) uut_ext (
        .clk(clk), .rst(rst), .sync_i(sync_i), .hit_i(hit_b), .sum_i(sum_e),
        .frame_o(fr_e), .frame_valid_o(v_e));

    function automatic logic [4:0] sumn(int ch, int p);
        return 5'((ch * 7 + p * 5 + 3) % 32);
    endfunction
    function automatic logic [12:0] sume(int ch, int p);
        return 13'((ch * 301 + p * 77 + 5) % 8192);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_plan();
        for (int c = 0; c < NCH; c++) begin
            fp[c] = -1;
            sp[c] = -1;
        end
    endtask

    // one cycle: check outputs, then drive period p of the plan
    task automatic step(input bit s, input int p);
        @(negedge clk);
        if (pending) begin
            chk(v_n && v_e, "R3 strobe after period 7", {v_n, v_e}, 2'b11);
            chk(fr_n == exp_n, "R4 R5 R6 R7 normal frame", fr_n, exp_n);
            chk(fr_e == exp_e, "R9 R5 R6 R7 extended frame", fr_e, exp_e);
            pending = 0;
        end else begin
            chk(!v_n && !v_e, "R3 R8 no strobe mid-frame", {v_n, v_e}, 2'b00);
        end
        sync_i = s;
        for (int c = 0; c < NCH; c++) begin
            hit_b[c] = (p >= 0) && (fp[c] == p || sp[c] == p);
            sum_n[c*5 +: 5]   = sumn(c, p < 0 ? 0 : p);
            sum_e[c*13 +: 13] = sume(c, p < 0 ? 0 : p);
        end
    endtask

    task automatic run_frame(input bit with_sync);
        for (int k = 0; k < 8; k++) step(with_sync && k == 0, k);
        for (int c = 0; c < NCH; c++) begin
            if (fp[c] >= 0) begin
                exp_n[c*8 +: 8]   = {3'(fp[c]), sumn(c, fp[c])};
                exp_e[c*16 +: 16] = {3'(fp[c]), sume(c, fp[c])};
            end else begin
                exp_n[c*8 +: 8]   = '0;
                exp_e[c*16 +: 16] = '0;
            end
        end
        pending = 1;
    endtask

    task automatic flush();
        logic [NCH*8-1:0] held;
        clear_plan();
        step(1'b0, -1);
        held = fr_n;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!v_n && fr_n == held, "R10 frame held between strobes", fr_n, held);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_plan();
        repeat (3) @(negedge clk);
        chk(!v_n && fr_n == '0 && !v_e && fr_e == '0, "R1 reset state", {v_n, fr_n}, '0);
        rst = 1'b0;
        // hits with no sync yet: nothing may come out
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!v_n && !v_e && fr_n == '0 && fr_e == '0, "R1 idle before sync",
                {v_n, fr_n}, '0);
            hit_b = '1;
            sum_n = '1;
            sum_e = '1;
        end
        @(negedge clk);
        hit_b = '0;

        // R5 R6 sweep: every channel at every period, back-to-back frames (R2)
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < 8; p++) begin
                clear_plan();
                fp[c] = p;
                sp[c] = (p < 7) ? 7 : -1;
                fp[(c + 5) % NCH] = (p + 3) % 8;
                run_frame((c == 0 && p == 0) || (p % 3 == 1));
            end
        end
        flush();

        // R4 all channels in one frame, channel k at period k mod 8
        clear_plan();
        for (int c = 0; c < NCH; c++) begin
            fp[c] = c % 8;
            sp[c] = (c % 8 < 6) ? 6 : -1;
        end
        run_frame(1'b1);
        flush();

        // R8 early sync discards partial frame
        clear_plan();
        fp[0] = 2;
        fp[3] = 4;
        for (int k = 0; k < 5; k++) step(k == 0, k);
        clear_plan();
        fp[1] = 0;
        fp[2] = 2;
        run_frame(1'b1);
        flush();

        // R2 auto-repeat without sync after an aligned frame
        clear_plan();
        fp[7] = 5;
        run_frame(1'b1);
        clear_plan();
        fp[9] = 3;
        fp[15] = 7;
        run_frame(1'b0);
        flush();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule